// File: doc/BRIEF.md
# Byte-Wide Host Command Front End for an Accumulator ALU

This block lets a host processor drive an accumulator ALU over a byte-wide data port. Each transaction has a fixed order. The host writes a command byte and then a 16-bit operand as two bytes. The block runs one ALU operation on its accumulator. The host then reads back the 16-bit accumulator and finally a packed flag byte. A single ready line tells the host when the next byte may move. The line falls after every completed byte and rises again once the sequencer can take or supply the following byte.

The command byte holds an opcode, an incoming carry for the carry-using operations, and three reserved bits. A command with any reserved bit set is thrown away, and the block goes back to waiting for a command byte. The operand is always sent, even for unary operations, where its value is ignored. The accumulator and its flags persist from one command to the next, so a chain of additions can be followed flag by flag. A second, sticky overflow flag and its sign companion record the net overflow over a run of arithmetic operations.

Top module: `alu_host_seq`

## Requirements
- R1: After reset the sequencer waits for a command byte with `rqm` high, and the accumulator and all six flags are zero. A NOP issued right after reset returns result 0x0000 and flag byte 0xC0.
- R2: A byte moves only on a clock edge where `rqm` is high and the strobe matches the expected direction (write for command and operand, read for result and flags). Such a transfer drops `rqm` in the next cycle. A strobe while `rqm` is low, or a strobe in the wrong direction, is ignored.
- R3: Command byte fields are bits 7:5 reserved (must be zero), bit 4 incoming carry, bits 3:0 opcode. A nonzero reserved field drops the command. The sequencer then waits for a new command byte, and the accumulator and flags are untouched.
- R4: Two operand bytes, low byte first, always follow an accepted command. Unary operations and NOP ignore their value.
- R5: After execution the host reads the accumulator low byte, then the high byte, then the flag byte. The flag byte is laid out from bit 7 down as 1, 1, S1, S0, C, Z, OV1, OV0.
- R6: Binary opcodes: 1 OR, 2 AND, 3 XOR, 4 SUB (A−B), 5 ADD, 6 SBB (A−B−carry), 7 ADC (A+B+carry), where B is the operand.
- R7: Unary opcodes: 8 DEC, 9 INC, 10 ones' complement, 11 arithmetic shift right by 1, 12 shift left by 1, 13 shift left by 2, 14 shift left by 4, 15 byte swap.
- R8: Arithmetic opcodes (4 to 9) set S0 to the result sign and Z when the result is zero. C is set on unsigned carry out for ADD, ADC and INC, and on borrow for SUB, SBB and DEC. OV0 is set when the signed result leaves the 16-bit range.
- R9: For arithmetic with OV0 set: if OV1 was clear, OV1 is set and S1 takes the true sign of the result. If OV1 was set and the true sign equals S1, OV1 stays set. Otherwise OV1 clears and S1 takes S0. For arithmetic without overflow, OV1 and S1 keep their values while OV1 is set; otherwise S1 takes S0.
- R10: Opcodes 1 to 3 and 10 to 15 clear C, OV0 and OV1, set S0 and S1 to the result sign, and set Z when the result is zero.
- R11: Opcode 0 (NOP) leaves the accumulator and every flag unchanged.
- R12: The accumulator and flags change only when an accepted command executes, and keep their values across transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_din | input | BYTE_W | Byte written by the host |
| host_dout | output | BYTE_W | Byte offered to the host during read phases, zero otherwise |
| rqm | output | 1 | Ready for the host to move the next byte |

## Verification
The assertions assume the host raises a strobe only while `rqm` is high, and that each strobe lasts one cycle except when the bench deliberately holds it into a gap cycle or pulses the wrong direction. The bench drives every strobe from the falling edge after it sees `rqm` high, so each strobe lands on exactly one rising edge. Random commands mix legal opcodes with occasional nonzero reserved bits. Operands are biased toward 0x0000, 0x7FFF, 0x8000 and 0xFFFF so that carries, overflows in both directions and the sticky overflow rules all occur often.

// File: rtl/alu_host_pkg.sv
package alu_host_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_OR   = 4'd1,
        OP_AND  = 4'd2,
        OP_XOR  = 4'd3,
        OP_SUB  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SBB  = 4'd6,
        OP_ADC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_INC  = 4'd9,
        OP_CPL  = 4'd10,
        OP_SHR1 = 4'd11,
        OP_SHL1 = 4'd12,
        OP_SHL2 = 4'd13,
        OP_SHL4 = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    // Bit order of this struct is the low six bits of the flag byte.
    typedef struct packed {
        logic s1;
        logic s0;
        logic c;
        logic z;
        logic ov1;
        logic ov0;
    } alu_flags_t;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_CHK,
        ST_OPL,
        ST_GAP_L,
        ST_OPH,
        ST_EXEC,
        ST_RESL,
        ST_GAP_R,
        ST_RESH,
        ST_GAP_H,
        ST_FLG,
        ST_GAP_F
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_FLG
    } rd_sel_e;

    localparam int CMD_OP_LSB   = 0;
    localparam int CMD_CIN_BIT  = 4;
    localparam int CMD_RSVD_LSB = 5;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_SUB) || (op == OP_ADD) || (op == OP_SBB) ||
               (op == OP_ADC) || (op == OP_DEC) || (op == OP_INC);
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op != OP_NOP) && !is_arith(op);
    endfunction

    function automatic logic is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
    endfunction

    function automatic logic [7:0] pack_flags(alu_flags_t f);
        return {2'b11, f};
    endfunction

endpackage

// File: rtl/alu_acc_core.sv
module alu_acc_core
    import alu_host_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec,
    input  alu_op_e      op,
    input  logic         cin,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc,
    output alu_flags_t   flags
);
    localparam int WX = W + 1;
    localparam int HW = W / 2;

    logic [W-1:0]  y;
    logic          ci;
    logic [WX-1:0] sum_x;
    logic [WX-1:0] dif_x;
    logic [W-1:0]  res;
    logic          ov_now;
    logic          true_neg;
    alu_flags_t    nf;

    // Second operand and carry-in for the arithmetic group
    always_comb begin
        y  = operand;
        ci = 1'b0;
        case (op)
            OP_ADC, OP_SBB: ci = cin;
            OP_INC, OP_DEC: y  = W'(1);
            default: ;
        endcase
    end

    assign sum_x = {1'b0, acc} + {1'b0, y} + WX'(ci);
    assign dif_x = {1'b0, acc} - {1'b0, y} - WX'(ci);

    always_comb begin
        res    = acc;
        ov_now = 1'b0;
        case (op)
            OP_OR:   res = acc | operand;
            OP_AND:  res = acc & operand;
            OP_XOR:  res = acc ^ operand;
            OP_CPL:  res = ~acc;
            OP_SHR1: res = {acc[W-1], acc[W-1:1]};
            OP_SHL1: res = acc << 1;
            OP_SHL2: res = acc << 2;
            OP_SHL4: res = acc << 4;
            OP_SWAP: res = {acc[HW-1:0], acc[W-1:HW]};
            OP_SUB, OP_SBB, OP_DEC: begin
                res    = dif_x[W-1:0];
                ov_now = (acc[W-1] != y[W-1]) && (res[W-1] != acc[W-1]);
            end
            OP_ADD, OP_ADC, OP_INC: begin
                res    = sum_x[W-1:0];
                ov_now = (acc[W-1] == y[W-1]) && (res[W-1] != acc[W-1]);
            end
            default: ;
        endcase
    end

    // On overflow the true sign is the opposite of the wrapped sign.
    assign true_neg = ~res[W-1];

    always_comb begin
        nf = flags;
        if (is_arith(op)) begin
            nf.s0  = res[W-1];
            nf.z   = (res == '0);
            nf.c   = is_sub(op) ? dif_x[W] : sum_x[W];
            nf.ov0 = ov_now;
            if (ov_now) begin
                if (!flags.ov1) begin
                    nf.ov1 = 1'b1;
                    nf.s1  = true_neg;
                end else if (true_neg == flags.s1) begin
                    nf.ov1 = 1'b1;
                end else begin
                    nf.ov1 = 1'b0;
                    nf.s1  = res[W-1];
                end
            end else if (!flags.ov1) begin
                nf.s1 = res[W-1];
            end
        end else if (is_logic(op)) begin
            nf.s0  = res[W-1];
            nf.s1  = res[W-1];
            nf.z   = (res == '0);
            nf.c   = 1'b0;
            nf.ov0 = 1'b0;
            nf.ov1 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            flags <= '0;
        end else if (exec) begin
            acc   <= res;
            flags <= nf;
        end
    end

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (exec && is_logic(op)) |=> (!flags.c && !flags.ov0 && !flags.ov1 && (flags.s1 == flags.s0))) // R10
        else $error("logic op left carry or overflow set");

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (exec && op == OP_NOP) |=> ($stable(acc) && $stable(flags))) // R11
        else $error("NOP changed state");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!exec) |=> ($stable(acc) && $stable(flags))) // R12
        else $error("state changed without execution");

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (exec && op != OP_NOP) |=> (flags.z == (acc == '0))) // R8
        else $error("zero flag disagrees with accumulator");

    AST_OV0_IMPLIES_OV1_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (exec && is_arith(op) && !flags.ov1) |=> (flags.ov1 == flags.ov0)) // R9
        else $error("sticky overflow not raised with first overflow");

endmodule

// File: rtl/host_seq_fsm.sv
module host_seq_fsm
    import alu_host_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [BYTE_W-1:0]     host_din,
    output logic                  rqm,
    output rd_sel_e               rd_sel,
    output logic                  exec,
    output alu_op_e               op,
    output logic                  cin,
    output logic [2*BYTE_W-1:0]   operand
);
    seq_state_e        st, st_n;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] opd_lo_q;
    logic [BYTE_W-1:0] opd_hi_q;
    logic              cmd_bad;
    logic              wr_ok;
    logic              rd_ok;

    assign cmd_bad = |cmd_q[BYTE_W-1:CMD_RSVD_LSB];
    assign op      = alu_op_e'(cmd_q[CMD_OP_LSB +: 4]);
    assign cin     = cmd_q[CMD_CIN_BIT];
    assign operand = {opd_hi_q, opd_lo_q};
    assign exec    = (st == ST_EXEC);

    always_comb begin
        rqm    = 1'b0;
        rd_sel = SEL_NONE;
        case (st)
            ST_CMD, ST_OPL, ST_OPH: rqm = 1'b1;
            ST_RESL: begin rqm = 1'b1; rd_sel = SEL_LO;  end
            ST_RESH: begin rqm = 1'b1; rd_sel = SEL_HI;  end
            ST_FLG:  begin rqm = 1'b1; rd_sel = SEL_FLG; end
            default: ;
        endcase
    end

    assign wr_ok = host_wr && rqm && (rd_sel == SEL_NONE);
    assign rd_ok = host_rd && rqm && (rd_sel != SEL_NONE);

    always_comb begin
        st_n = st;
        case (st)
            ST_CMD:   if (wr_ok) st_n = ST_CHK;
            ST_CHK:   st_n = cmd_bad ? ST_CMD : ST_OPL;
            ST_OPL:   if (wr_ok) st_n = ST_GAP_L;
            ST_GAP_L: st_n = ST_OPH;
            ST_OPH:   if (wr_ok) st_n = ST_EXEC;
            ST_EXEC:  st_n = ST_RESL;
            ST_RESL:  if (rd_ok) st_n = ST_GAP_R;
            ST_GAP_R: st_n = ST_RESH;
            ST_RESH:  if (rd_ok) st_n = ST_GAP_H;
            ST_GAP_H: st_n = ST_FLG;
            ST_FLG:   if (rd_ok) st_n = ST_GAP_F;
            ST_GAP_F: st_n = ST_CMD;
            default:  st_n = ST_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_CMD;
            cmd_q    <= '0;
            opd_lo_q <= '0;
            opd_hi_q <= '0;
        end else begin
            st <= st_n;
            if (wr_ok && st == ST_CMD) cmd_q    <= host_din;
            if (wr_ok && st == ST_OPL) opd_lo_q <= host_din;
            if (wr_ok && st == ST_OPH) opd_hi_q <= host_din;
        end
    end

    AST_WR_DROPS_RQM: assert property (@(posedge clk) disable iff (rst)
        (rqm && host_wr && rd_sel == SEL_NONE) |=> !rqm) // R2
        else $error("rqm stayed high after a write");

    AST_RD_DROPS_RQM: assert property (@(posedge clk) disable iff (rst)
        (rqm && host_rd && rd_sel != SEL_NONE) |=> !rqm) // R2
        else $error("rqm stayed high after a read");

    AST_BAD_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHK && cmd_bad) |=> (st == ST_CMD && rqm && !exec)) // R3
        else $error("reserved-bit command not dropped");

    AST_RESULT_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        exec |=> (rqm && rd_sel == SEL_LO && !exec)) // R5
        else $error("result low byte not offered after execution");

endmodule

// File: rtl/host_rd_mux.sv
module host_rd_mux
    import alu_host_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  rd_sel_e               rd_sel,
    input  logic [2*BYTE_W-1:0]   acc,
    input  alu_flags_t            flags,
    output logic [BYTE_W-1:0]     dout
);
    logic [BYTE_W-1:0] flag_byte;

    always_comb begin
        flag_byte      = '0;
        flag_byte[7:0] = pack_flags(flags);
    end

    always_comb begin
        case (rd_sel)
            SEL_LO:  dout = acc[BYTE_W-1:0];
            SEL_HI:  dout = acc[2*BYTE_W-1:BYTE_W];
            SEL_FLG: dout = flag_byte;
            default: dout = '0;
        endcase
    end

    always_comb begin
        if (rd_sel == SEL_FLG)
            AST_FLAG_TOP_ONES: assert (dout[7:6] == 2'b11); // R5
    end

endmodule

// File: rtl/alu_host_seq.sv
module alu_host_seq
    import alu_host_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              rqm
);
    localparam int WORD_W = 2 * BYTE_W;

    rd_sel_e           rd_sel;
    logic              exec;
    alu_op_e           op;
    logic              cin;
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] acc;
    alu_flags_t        flags;

    host_seq_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .host_din (host_din),
        .rqm      (rqm),
        .rd_sel   (rd_sel),
        .exec     (exec),
        .op       (op),
        .cin      (cin),
        .operand  (operand)
    );

    alu_acc_core #(.W(WORD_W)) u_alu (
        .clk      (clk),
        .rst      (rst),
        .exec     (exec),
        .op       (op),
        .cin      (cin),
        .operand  (operand),
        .acc      (acc),
        .flags    (flags)
    );

    host_rd_mux #(.BYTE_W(BYTE_W)) u_mux (
        .rd_sel   (rd_sel),
        .acc      (acc),
        .flags    (flags),
        .dout     (host_dout)
    );

endmodule

// File: tb/alu_host_seq_tb_top.sv
module alu_host_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       rqm;

    always #2 clk = ~clk;

    alu_host_seq #(.BYTE_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_din  (host_din),
        .host_dout (host_dout),
        .rqm       (rqm)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the accumulator and flags
    logic [15:0] m_acc = 16'h0000;
    logic m_s1 = 0, m_s0 = 0, m_c = 0, m_z = 0, m_ov1 = 0, m_ov0 = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_flag_byte();
        return {2'b11, m_s1, m_s0, m_c, m_z, m_ov1, m_ov0};
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        if (op == 4'd0) return "R11";
        if (op <= 4'd7) return "R6";
        return "R7";
    endfunction

    function automatic string flag_tag(input logic [3:0] op);
        if (op == 4'd0) return "R11";
        if (op >= 4'd4 && op <= 4'd9) return "R9";
        return "R10";
    endfunction

    task automatic model_exec(input logic [3:0] op, input logic cin, input logic [15:0] b);
        logic [15:0] r;
        int sa, sb, tv, ua, ub, ci;
        logic ov, t;
        sa = int'($signed(m_acc));
        sb = int'($signed(b));
        ua = int'(m_acc);
        ub = int'(b);
        ci = int'(cin);
        if (op == 4'd0) return;
        if (op >= 4'd4 && op <= 4'd9) begin
            case (op)
                4'd4: begin tv = sa - sb;      m_c = (ua < ub);          end
                4'd5: begin tv = sa + sb;      m_c = (ua + ub > 65535);  end
                4'd6: begin tv = sa - sb - ci; m_c = (ua < ub + ci);     end
                4'd7: begin tv = sa + sb + ci; m_c = (ua + ub + ci > 65535); end
                4'd8: begin tv = sa - 1;       m_c = (ua < 1);           end
                default: begin tv = sa + 1;    m_c = (ua + 1 > 65535);   end
            endcase
            r  = tv[15:0];
            ov = (tv > 32767) || (tv < -32768);
            t  = (tv < 0);
            m_ov0 = ov;
            if (ov) begin
                if (!m_ov1) begin m_ov1 = 1; m_s1 = t; end
                else if (t != m_s1) begin m_ov1 = 0; m_s1 = r[15]; end
            end else if (!m_ov1) begin
                m_s1 = r[15];
            end
        end else begin
            case (op)
                4'd1:  r = m_acc | b;
                4'd2:  r = m_acc & b;
                4'd3:  r = m_acc ^ b;
                4'd10: r = ~m_acc;
                4'd11: r = 16'($signed(m_acc) >>> 1);
                4'd12: r = m_acc << 1;
                4'd13: r = m_acc << 2;
                4'd14: r = m_acc << 4;
                default: r = {m_acc[7:0], m_acc[15:8]};
            endcase
            m_c = 0; m_ov0 = 0; m_ov1 = 0; m_s1 = r[15];
        end
        m_acc = r;
        m_s0  = r[15];
        m_z   = (r == 16'h0000);
    endtask

    task automatic wait_rqm();
        @(negedge clk);
        while (!rqm) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        wait_rqm();
        host_din = b;
        host_wr  = 1'b1;
        @(negedge clk);
        host_wr  = 1'b0;
        check("R2 rqm low after write", int'(rqm), 0);
    endtask

    task automatic get_byte(output logic [7:0] b);
        wait_rqm();
        b       = host_dout;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R2 rqm low after read", int'(rqm), 0);
    endtask

    // Full transaction with model comparison; returns observed values
    task automatic run_txn(input logic [7:0] cmd, input logic [15:0] opnd,
                           output logic [15:0] res, output logic [7:0] fl);
        logic [7:0] lo, hi;
        put_byte(cmd);
        if (cmd[7:5] != 3'b000) begin
            res = 16'hxxxx;
            fl  = 8'hxx;
            return;
        end
        put_byte(opnd[7:0]);
        put_byte(opnd[15:8]);
        model_exec(cmd[3:0], cmd[4], opnd);
        get_byte(lo);
        get_byte(hi);
        get_byte(fl);
        res = {hi, lo};
        check(res_tag(cmd[3:0]), int'(res), int'(m_acc));
        check(flag_tag(cmd[3:0]), int'(fl), int'(m_flag_byte()));
    endtask

    function automatic logic [15:0] pick_operand();
        case ($urandom_range(0, 7))
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            4: return 16'h0001;
            default: return 16'($urandom());
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] res, keep;
        logic [7:0]  fl, lo, hi;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rqm high after reset", int'(rqm), 1);

        // R1 / R11: NOP right after reset
        run_txn(8'h00, 16'h1234, res, fl);
        check("R1 reset accumulator", int'(res), 16'h0000);
        check("R1 reset flag byte", int'(fl), 8'hC0);

        // R9 / R5: first overflow, then cancel in the opposite direction
        run_txn(8'h01, 16'h7FFF, res, fl);
        run_txn(8'h05, 16'h0001, res, fl);
        check("R5 flag layout after positive overflow", int'(fl), 8'hD3);
        run_txn(8'h04, 16'h0001, res, fl);
        check("R9 opposite overflow clears OV1", int'(fl), 8'hC1);

        // R9: same-direction overflow keeps OV1
        run_txn(8'h09, 16'h0000, res, fl);
        run_txn(8'h05, 16'h7FFF, res, fl);
        check("R9 no overflow keeps OV1", int'(fl), 8'hD2);
        run_txn(8'h05, 16'h7FFF, res, fl);
        check("R8 carry out of ADD", int'(fl[3]), 1);
        run_txn(8'h05, 16'h7FFF, res, fl);
        check("R9 same-direction overflow keeps OV1", int'(fl), 8'hD3);

        // R8: borrow, and ADC/SBB consuming the carry bit
        run_txn(8'h01, 16'h0000, res, fl);
        run_txn(8'h02, 16'h0000, res, fl);
        run_txn(8'h08, 16'hABCD, res, fl);
        check("R8 DEC borrow from zero", int'(fl[3]), 1);
        run_txn(8'h17, 16'h0001, res, fl);
        check("R8 ADC with carry-in", int'(res), 16'h0001);
        run_txn(8'h16, 16'h0000, res, fl);
        check("R8 SBB with carry-in to zero", int'(fl[2]), 1);

        // R4: unary op ignores operand value
        run_txn(8'h09, 16'hFFFF, res, fl);
        keep = res;
        run_txn(8'h08, 16'h0000, res, fl);
        run_txn(8'h09, 16'h5A5A, res, fl);
        check("R4 dummy operand ignored", int'(res), int'(keep));

        // R3 / R12: reserved bits set, command dropped and state unchanged
        keep = m_acc;
        run_txn(8'hE5, 16'h0000, res, fl);
        run_txn(8'h25, 16'h0000, res, fl);
        run_txn(8'h00, 16'h0101, res, fl);
        check("R3 dropped command left accumulator", int'(res), int'(keep));
        check("R12 flags persist across commands", int'(fl), int'(m_flag_byte()));

        // R2: wrong-direction strobes and a strobe held into a gap cycle
        wait_rqm();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R2 read during command wait ignored", int'(rqm), 1);
        put_byte(8'h05);
        wait_rqm();
        host_din = 8'h10;
        host_wr  = 1'b1;
        @(negedge clk);
        host_din = 8'hEE;
        @(negedge clk);
        host_wr  = 1'b0;
        check("R2 write in gap ignored", int'(rqm), 1);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R2 read during operand wait ignored", int'(rqm), 1);
        put_byte(8'h00);
        model_exec(4'd5, 1'b0, 16'h0010);
        wait_rqm();
        host_din = 8'h77;
        host_wr  = 1'b1;
        @(negedge clk);
        host_wr  = 1'b0;
        check("R2 write during result wait ignored", int'(rqm), 1);
        get_byte(lo);
        get_byte(hi);
        get_byte(fl);
        check("R5 result low then high", int'({hi, lo}), int'(m_acc));
        check("R5 flag byte order", int'(fl), int'(m_flag_byte()));

        // Random mix
        for (int i = 0; i < 500; i++) begin
            logic [7:0] cmd;
            cmd = {3'b000, 1'($urandom()), 4'($urandom())};
            if ($urandom_range(0, 7) == 0) cmd[7:5] = 3'($urandom_range(1, 7));
            run_txn(cmd, pick_operand(), res, fl);
        end
        run_txn(8'h00, 16'h0000, res, fl);
        check("R12 final persistence", int'(res), int'(m_acc));

        finish_run();
    end

endmodule